// File: doc/BRIEF.md
# Adaptive Compression Allocation Predictor

This block decides, one cache access at a time, whether lines about to be allocated into a compressed cache set should be stored in compressed form. It learns from each access whether storing lines compressed would have helped or hurt. The cache reports the access as a hit or a miss. It also gives the 1-based recency depth of the matching tag (0 when no tag matched), whether the matched line is held compressed, and the stored size in segments of every tag position in the set.

From these inputs the block sorts each access into one of five classes:
- Hits within the uncompressed way count, split into compressed and uncompressed lines.
- Hits deeper than the uncompressed way count.
- Misses that a fully compressed set would have held.
- Misses that no amount of compression would have saved.

A single signed saturating counter adds up benefits (weighted by memory latency) and costs (weighted by decompression latency). The allocation flag is the counter's sign test. An optional normalised weighting replaces the cost step with 1 and the benefit step with the latency ratio.

Top module: `cmp_predictor`

## Requirements
- R1: After reset the counter reads 0 and the allocate-compressed flag is 1.
- R2: A valid hit at depth at most UNC_WAYS (default 2), including depth 0, to an uncompressed line leaves the counter unchanged.
- R3: A valid hit at depth at most UNC_WAYS to a compressed line lowers the counter by decLat.
- R4: A valid hit at depth greater than UNC_WAYS raises the counter by memLat.
- R5: A valid miss with depth d in 1..NUM_TAGS (default 4) raises the counter by memLat when the stored sizes of depths 1..d sum to at most SEG_CAP (default 16). Depth k's size sits in accSizes bits [k*SIZE_W-1 -: SIZE_W].
- R6: A valid miss with depth in 1..NUM_TAGS whose size sum exceeds SEG_CAP leaves the counter unchanged.
- R7: A valid miss with depth 0 or depth greater than NUM_TAGS leaves the counter unchanged.
- R8: While accValid is 0 the counter holds, whatever the other access inputs carry.
- R9: allocComp is 1 exactly when the counter is zero or positive.
- R10: The counter clamps at 2^(CNT_W-1)-1 (262143 for the default of 19 bits) instead of wrapping.
- R11: The counter clamps at -2^(CNT_W-1) (-262144 by default) instead of wrapping.
- R12: With normMode set, the cost step is 1 and the benefit step is floor(memLat / max(decLat,1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accHit | input | 1 | Access hit in the cache |
| accDepth | input | DEP_W | 1-based recency depth of matching tag, 0 if none |
| accLineComp | input | 1 | Matched line is stored compressed |
| accSizes | input | NUM_TAGS*SIZE_W | Stored size in segments per depth, depth 1 in the low field |
| memLat | input | LAT_W | Benefit weight (memory latency in cycles) |
| decLat | input | LAT_W | Cost weight (decompression latency in cycles) |
| normMode | input | 1 | Select normalised weights |
| allocComp | output | 1 | Allocate new lines compressed |
| predCount | output | CNT_W | Signed predictor counter value |

## Verification
The bound checker watches every cycle. It checks that the counter holds during idle cycles, on unpenalized hits and on tagless misses. It checks that penalized hits never raise the counter and avoided misses never lower it, and that neither end of the range wraps. The exact step sizes cannot be seen by those properties: memLat, decLat, the normalised ratio, the segment-sum boundary at exactly SEG_CAP and the sign flip of the allocation flag. The bench scenarios show these, with a behavioural model that is compared on every clock.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_UNPEN,
    ACC_PEN,
    ACC_AVOIDED,
    ACC_AVOIDABLE,
    ACC_UNAVOID
  } accClass_e;

  typedef struct packed {
    logic bump;
    logic drop;
  } cntCmd_t;
endpackage

// File: rtl/cmp_classify.sv
module cmp_classify
  import cmp_pkg::*;
#(
  parameter int NUM_TAGS = 4,
  parameter int UNC_WAYS = 2,
  parameter int SEG_CAP  = 16,
  parameter int SIZE_W   = 4,
  parameter int DEP_W    = 4
) (
  input  logic                       accValid,
  input  logic                       accHit,
  input  logic [DEP_W-1:0]           accDepth,
  input  logic                       accLineComp,
  input  logic [NUM_TAGS*SIZE_W-1:0] accSizes,
  output cntCmd_t                    cmd
);
  localparam int SUM_W = SIZE_W + $clog2(NUM_TAGS) + 2;

  logic [SUM_W-1:0] depthSum;
  logic             tagInRange;
  logic             shallow;
  accClass_e        cls;

  // Sum stored sizes of every position from the top of the stack down to the matched depth
  always_comb begin
    depthSum = '0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (DEP_W'(i) < accDepth) depthSum = depthSum + SUM_W'(accSizes[i*SIZE_W +: SIZE_W]);
    end
  end

  assign tagInRange = (accDepth != '0) && (accDepth <= DEP_W'(NUM_TAGS));
  assign shallow    = (accDepth <= DEP_W'(UNC_WAYS));

  always_comb begin
    cls = ACC_IDLE;
    if (accValid) begin
      if (accHit) begin
        if (shallow) cls = accLineComp ? ACC_PEN : ACC_UNPEN;
        else         cls = ACC_AVOIDED;
      end else if (tagInRange && (depthSum <= SUM_W'(SEG_CAP))) begin
        cls = ACC_AVOIDABLE;
      end else begin
        cls = ACC_UNAVOID;
      end
    end
  end

  assign cmd.bump = (cls == ACC_AVOIDED) || (cls == ACC_AVOIDABLE);
  assign cmd.drop = (cls == ACC_PEN);
endmodule

// File: rtl/cmp_counter.sv
module cmp_counter
  import cmp_pkg::*;
#(
  parameter int CNT_W = 19,
  parameter int LAT_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cntCmd_t                 cmd,
  input  logic                    normMode,
  input  logic [LAT_W-1:0]        memLat,
  input  logic [LAT_W-1:0]        decLat,
  output logic signed [CNT_W-1:0] cnt
);
  localparam int EXT = CNT_W + 2;
  localparam logic signed [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};

  logic [LAT_W-1:0]      safeDiv;
  logic [LAT_W-1:0]      upStep;
  logic [LAT_W-1:0]      downStep;
  logic signed [EXT-1:0] cntExt;
  logic signed [EXT-1:0] wide;
  logic signed [CNT_W-1:0] nextCnt;

  assign safeDiv  = (decLat == '0) ? LAT_W'(1) : decLat;
  assign upStep   = normMode ? (memLat / safeDiv) : memLat;
  assign downStep = normMode ? LAT_W'(1) : decLat;
  assign cntExt   = {{2{cnt[CNT_W-1]}}, cnt};

  always_comb begin
    wide = cntExt;
    if (cmd.bump)      wide = cntExt + $signed({{(EXT-LAT_W){1'b0}}, upStep});
    else if (cmd.drop) wide = cntExt - $signed({{(EXT-LAT_W){1'b0}}, downStep});
    if (wide > $signed({{2{1'b0}}, MAXV}))      nextCnt = MAXV;
    else if (wide < $signed({{2{1'b1}}, MINV})) nextCnt = MINV;
    else                                        nextCnt = wide[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nextCnt;
  end
endmodule

// File: rtl/cmp_predictor.sv
module cmp_predictor
  import cmp_pkg::*;
#(
  parameter int CNT_W    = 19,
  parameter int LAT_W    = 10,
  parameter int NUM_TAGS = 4,
  parameter int UNC_WAYS = 2,
  parameter int SEG_CAP  = 16,
  parameter int SIZE_W   = 4,
  parameter int DEP_W    = $clog2(NUM_TAGS + 1) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       accValid,
  input  logic                       accHit,
  input  logic [DEP_W-1:0]           accDepth,
  input  logic                       accLineComp,
  input  logic [NUM_TAGS*SIZE_W-1:0] accSizes,
  input  logic [LAT_W-1:0]           memLat,
  input  logic [LAT_W-1:0]           decLat,
  input  logic                       normMode,
  output logic                       allocComp,
  output logic signed [CNT_W-1:0]    predCount
);
  cntCmd_t cmd;

  cmp_classify #(
    .NUM_TAGS(NUM_TAGS), .UNC_WAYS(UNC_WAYS), .SEG_CAP(SEG_CAP),
    .SIZE_W(SIZE_W), .DEP_W(DEP_W)
  ) uClassify (
    .accValid(accValid), .accHit(accHit), .accDepth(accDepth),
    .accLineComp(accLineComp), .accSizes(accSizes), .cmd(cmd)
  );

  cmp_counter #(.CNT_W(CNT_W), .LAT_W(LAT_W)) uCounter (
    .clk(clk), .rstN(rstN), .cmd(cmd), .normMode(normMode),
    .memLat(memLat), .decLat(decLat), .cnt(predCount)
  );

  assign allocComp = ~predCount[CNT_W-1];
endmodule

// File: rtl/cmp_predictor_chk.sv
module cmp_predictor_chk #(
  parameter int CNT_W    = 19,
  parameter int NUM_TAGS = 4,
  parameter int UNC_WAYS = 2,
  parameter int DEP_W    = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    accValid,
  input logic                    accHit,
  input logic [DEP_W-1:0]        accDepth,
  input logic                    accLineComp,
  input logic signed [CNT_W-1:0] predCount
);
  localparam logic signed [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};

  logic shallowHit, deepHit, noTagMiss;
  assign shallowHit = accValid && accHit && (accDepth <= DEP_W'(UNC_WAYS));
  assign deepHit    = accValid && accHit && (accDepth > DEP_W'(UNC_WAYS));
  assign noTagMiss  = accValid && !accHit && ((accDepth == '0) || (accDepth > DEP_W'(NUM_TAGS)));

  // R2
  unpen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shallowHit && !accLineComp) |=> $stable(predCount));
  // R3
  cost_nonrise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shallowHit && accLineComp) |=> (predCount <= $past(predCount)));
  // R4
  avoided_nonfall_chk: assert property (@(posedge clk) disable iff (!rstN)
    deepHit |=> (predCount >= $past(predCount)));
  // R7
  notag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    noTagMiss |=> $stable(predCount));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> $stable(predCount));
  // R10
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deepHit && (predCount == MAXV)) |=> (predCount == MAXV));
  // R11
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shallowHit && accLineComp && (predCount == MINV)) |=> (predCount == MINV));
endmodule

bind cmp_predictor cmp_predictor_chk #(
  .CNT_W(CNT_W), .NUM_TAGS(NUM_TAGS), .UNC_WAYS(UNC_WAYS), .DEP_W(DEP_W)
) uChk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit),
  .accDepth(accDepth), .accLineComp(accLineComp), .predCount(predCount)
);

// File: tb/sim_cmp_predictor.sv
module sim_cmp_predictor;
  timeunit 1ns; timeprecision 1ps;

  localparam int CNT_W = 19, LAT_W = 10, NUM_TAGS = 4, SIZE_W = 4, DEP_W = 4;
  localparam int UNC = 2, CAP = 16;
  localparam int MAXV = (1 << (CNT_W-1)) - 1;
  localparam int MINV = -(1 << (CNT_W-1));

  logic clk = 0, rstN = 0;
  logic accValid = 0, accHit = 0, accLineComp = 0, normMode = 0;
  logic [DEP_W-1:0] accDepth = '0;
  logic [NUM_TAGS*SIZE_W-1:0] accSizes = '0;
  logic [LAT_W-1:0] memLat = 10'd400, decLat = 10'd5;
  logic allocComp;
  logic signed [CNT_W-1:0] predCount;

  int checks = 0, failures = 0;
  int model = 0;
  bit running = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  cmp_predictor u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit),
    .accDepth(accDepth), .accLineComp(accLineComp), .accSizes(accSizes),
    .memLat(memLat), .decLat(decLat), .normMode(normMode),
    .allocComp(allocComp), .predCount(predCount)
  );

  function automatic int stepOf();
    int d = accDepth, sum = 0, ml = memLat, dl = decLat, up, dn;
    dn = normMode ? 1 : dl;
    up = normMode ? ml / ((dl == 0) ? 1 : dl) : ml;
    for (int k = 1; k <= NUM_TAGS; k++) if (k <= d) sum += accSizes[(k-1)*SIZE_W +: SIZE_W];
    if (!accValid) return 0;
    if (accHit) return (d <= UNC) ? (accLineComp ? -dn : 0) : up;
    if (d >= 1 && d <= NUM_TAGS && sum <= CAP) return up;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) model = 0;
    else begin
      model = model + stepOf();
      if (model > MAXV) model = MAXV;
      if (model < MINV) model = MINV;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && running) begin
      chk(curTag, int'(predCount), model);
      chk("R9", int'(allocComp), (model >= 0) ? 1 : 0);
    end
  end

  function automatic logic [15:0] sz(int a, int b, int c, int d);
    return {4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  task automatic acc(string tag, bit v, bit h, int d, bit c, logic [15:0] s);
    curTag = tag;
    accValid = v; accHit = h; accDepth = DEP_W'(d); accLineComp = c; accSizes = s;
    @(posedge clk); #1;
    accValid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(predCount), 0);
    chk("R1", int'(allocComp), 1);
    rstN = 1; running = 1;
    @(negedge clk);
    chk("R1", int'(predCount), 0);

    acc("R2", 1, 1, 1, 0, sz(3, 2, 6, 4));
    chk("R2", int'(predCount), 0);
    acc("R2", 1, 1, 0, 0, sz(3, 2, 6, 4));
    chk("R2", int'(predCount), 0);
    acc("R3", 1, 1, 2, 1, sz(3, 2, 6, 4));
    chk("R3", int'(predCount), -5);
    chk("R9", int'(allocComp), 0);
    acc("R4", 1, 1, 3, 1, sz(3, 2, 6, 4));
    chk("R4", int'(predCount), 395);
    acc("R5", 1, 0, 4, 0, sz(3, 2, 6, 4));
    chk("R5", int'(predCount), 795);
    acc("R5", 1, 0, 4, 0, sz(4, 2, 6, 4));
    chk("R5", int'(predCount), 1195);
    acc("R6", 1, 0, 4, 0, sz(5, 2, 6, 4));
    chk("R6", int'(predCount), 1195);
    acc("R6", 1, 0, 2, 0, sz(15, 15, 0, 0));
    chk("R6", int'(predCount), 1195);
    acc("R7", 1, 0, 0, 0, sz(0, 0, 0, 0));
    chk("R7", int'(predCount), 1195);
    acc("R7", 1, 0, 6, 0, sz(0, 0, 0, 0));
    chk("R7", int'(predCount), 1195);
    acc("R7", 1, 0, 15, 0, sz(0, 0, 0, 0));
    chk("R7", int'(predCount), 1195);
    acc("R8", 0, 1, 3, 1, sz(1, 1, 1, 1));
    chk("R8", int'(predCount), 1195);
    acc("R8", 0, 1, 1, 1, sz(1, 1, 1, 1));
    chk("R8", int'(predCount), 1195);

    normMode = 1;
    acc("R12", 1, 1, 3, 0, sz(0, 0, 0, 0));
    chk("R12", int'(predCount), 1275);
    acc("R12", 1, 1, 1, 1, sz(0, 0, 0, 0));
    chk("R12", int'(predCount), 1274);
    decLat = 10'd0;
    acc("R12", 1, 0, 1, 0, sz(2, 0, 0, 0));
    chk("R12", int'(predCount), 1674);
    decLat = 10'd7;
    acc("R12", 1, 1, 4, 0, sz(0, 0, 0, 0));
    chk("R12", int'(predCount), 1731);
    normMode = 0;

    memLat = 10'd1023;
    for (int i = 0; i < 300; i++) acc("R10", 1, 1, 3, 0, sz(0, 0, 0, 0));
    chk("R10", int'(predCount), MAXV);
    acc("R10", 1, 0, 1, 0, sz(1, 0, 0, 0));
    chk("R10", int'(predCount), MAXV);

    decLat = 10'd1023;
    for (int i = 0; i < 600; i++) acc("R11", 1, 1, 2, 1, sz(0, 0, 0, 0));
    chk("R11", int'(predCount), MINV);
    chk("R9", int'(allocComp), 0);
    acc("R11", 1, 1, 1, 1, sz(0, 0, 0, 0));
    chk("R11", int'(predCount), MINV);
    acc("R4", 1, 1, 4, 0, sz(0, 0, 0, 0));
    chk("R4", int'(predCount), MINV + 1023);

    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule